// File: doc/BRIEF.md
# Half-Duplex Backpressure Jam Controller

This block applies flow control on a half-duplex link by forcing collisions on purpose while the local receive buffer is close to overflowing. It watches the receive buffer fill level, a buffer-full flag and a programmable threshold. Once the buffer is in trouble it arms itself. It then lets any local transmission in progress end, and waits for the start of a fresh incoming frame. Only at that point does it ask the transmitter to send a jam pattern. The collision makes the remote sender back off, and the continued jam keeps other stations deferring.

A jam is never started partway through a received frame, so the collision it causes is always an early one. The block does nothing in full-duplex mode. Backoff, normal collision handling and the buffer itself belong to other blocks. The transmitter reads `jam_req` and sends `jam_data` on its data lanes while `jam_req` is high.

Top module: `bp_jam_ctrl`

## Requirements
- R1: After reset, `jam_req` is 0 and `jam_data` is 0.
- R2: The block arms when `half_duplex` is 1 and either `rx_full` is 1 or `rx_level >= rx_thresh` (unsigned). When the block is not armed, a pulse on `rx_sof` causes no jam.
- R3: While `half_duplex` is 0, no jam is requested. If `half_duplex` drops during a jam, `jam_req` is 0 after the next clock edge.
- R4: While the block is armed and `tx_busy` is 1, `rx_sof` is ignored. A jam can start only after `tx_busy` has returned to 0.
- R5: Arming takes one clock edge. Once the block is armed and `tx_busy` is 0, a 1 on `rx_sof` at a clock edge raises `jam_req` right after that edge. An `rx_sof` in the same cycle that the arming condition first appears is not acted upon.
- R6: Once started, the jam continues while `rx_crs` is 1 or the arming condition holds. `jam_req` falls after the first clock edge at which both are false.
- R7: If the arming condition goes away before a frame starts, the block disarms, and a later `rx_sof` with the buffer below threshold produces no jam.
- R8: While `jam_req` is 1, `jam_data` carries the alternating pattern with odd bit positions at 1 and even positions at 0 (4'b1010 for a 4-bit lane, bit 3 first). While `jam_req` is 0, `jam_data` is all zeros.
- R9: If a frame is already being received when the block arms (`rx_crs` high, no `rx_sof`), no jam is sent during that frame. The jam waits for the next `rx_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_duplex | input | 1 | 1 when the link runs half duplex |
| rx_level | input | LVL_W | Current receive buffer fill level |
| rx_thresh | input | LVL_W | Level at or above which backpressure arms |
| rx_full | input | 1 | Receive buffer full flag |
| tx_busy | input | 1 | Local transmitter is sending a frame |
| rx_sof | input | 1 | One-cycle pulse at the start of a received frame |
| rx_crs | input | 1 | Receive carrier present |
| jam_req | output | 1 | Request to the transmitter to send jam |
| jam_data | output | DATA_W | Jam pattern to place on the transmit lanes |

## Verification
The hardest cases to reach are the ones where arming overlaps other activity: arming while the transmitter is busy, arming while a frame is already on the wire, and arming in the same cycle as a frame start. The stimulus builds each of these by setting the level, `tx_busy` and `rx_crs` one cycle ahead and then placing the `rx_sof` pulse on a chosen edge. A full sweep of every threshold, level and full-flag combination in a 4-bit configuration checks the arming comparison against arithmetic done in the bench.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        BP_IDLE  = 2'd0,
        BP_DRAIN = 2'd1,
        BP_WAIT  = 2'd2,
        BP_JAM   = 2'd3
    } bp_state_e;

    typedef struct packed {
        bp_state_e state;
        logic      jam;
    } bp_regs_t;
endpackage

// File: rtl/bp_level_cmp.sv
module bp_level_cmp #(
    parameter int LVL_W = 14
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    input  logic             full,
    output logic             over
);
    // Arming condition: buffer full or level at/above threshold.
    always_comb begin
        over = full | (level >= thresh);
    end
endmodule

// File: rtl/bp_jam_fsm.sv
module bp_jam_fsm
    import bp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic half_duplex,
    input  logic over,
    input  logic tx_busy,
    input  logic rx_sof,
    input  logic rx_crs,
    output logic jam_req
);
    bp_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            BP_IDLE: begin
                if (half_duplex && over)
                    r_d.state = tx_busy ? BP_DRAIN : BP_WAIT;
            end
            BP_DRAIN: begin
                if (!half_duplex || !over) r_d.state = BP_IDLE;
                else if (!tx_busy)         r_d.state = BP_WAIT;
            end
            BP_WAIT: begin
                if (!half_duplex || !over) r_d.state = BP_IDLE;
                else if (tx_busy)          r_d.state = BP_DRAIN;
                else if (rx_sof)           r_d.state = BP_JAM;
            end
            BP_JAM: begin
                if (!half_duplex || (!over && !rx_crs)) r_d.state = BP_IDLE;
            end
            default: r_d.state = BP_IDLE;
        endcase
        r_d.jam = (r_d.state == BP_JAM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= BP_IDLE;
            r_q.jam   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign jam_req = r_q.jam;

    assert_fd_blocks_jam_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !half_duplex |=> !jam_req);

    assert_jam_after_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_req) |-> $past(rx_sof));

    assert_no_jam_from_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_req) |-> !$past(tx_busy));

    assert_jam_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (jam_req && half_duplex && (rx_crs || over)) |=> jam_req);

    assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == BP_WAIT && !over) |=> (r_q.state == BP_IDLE && !jam_req));
endmodule

// File: rtl/bp_jam_pattern.sv
module bp_jam_pattern #(
    parameter int DATA_W = 4
) (
    input  logic              jam_req,
    output logic [DATA_W-1:0] jam_data
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        localparam logic ODD = ((i % 2) == 1);
        assign jam_data[i] = jam_req & ODD;
    end
endmodule

// File: rtl/bp_jam_ctrl.sv
module bp_jam_ctrl #(
    parameter int LVL_W  = 14,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_duplex,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  rx_thresh,
    input  logic              rx_full,
    input  logic              tx_busy,
    input  logic              rx_sof,
    input  logic              rx_crs,
    output logic              jam_req,
    output logic [DATA_W-1:0] jam_data
);
    logic over;

    bp_level_cmp #(.LVL_W(LVL_W)) u_cmp (
        .level (rx_level),
        .thresh(rx_thresh),
        .full  (rx_full),
        .over  (over)
    );

    bp_jam_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_duplex(half_duplex),
        .over       (over),
        .tx_busy    (tx_busy),
        .rx_sof     (rx_sof),
        .rx_crs     (rx_crs),
        .jam_req    (jam_req)
    );

    bp_jam_pattern #(.DATA_W(DATA_W)) u_pat (
        .jam_req (jam_req),
        .jam_data(jam_data)
    );

    assert_idle_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !jam_req |-> (jam_data == '0));
endmodule

// File: tb/bp_jam_ctrl_tb.sv
module bp_jam_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 4;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          half_duplex = 1'b1;
    logic [LW-1:0] rx_level = '0;
    logic [LW-1:0] rx_thresh = '1;
    logic          rx_full = 1'b0;
    logic          tx_busy = 1'b0;
    logic          rx_sof = 1'b0;
    logic          rx_crs = 1'b0;
    logic          jam_req;
    logic [DW-1:0] jam_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_jam_ctrl #(.LVL_W(LW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex),
        .rx_level(rx_level), .rx_thresh(rx_thresh), .rx_full(rx_full),
        .tx_busy(tx_busy), .rx_sof(rx_sof), .rx_crs(rx_crs),
        .jam_req(jam_req), .jam_data(jam_data)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic exp_jam);
        logic [DW-1:0] exp_data;
        exp_data = exp_jam ? 4'b1010 : 4'b0000;
        n_run++;
        if (jam_req !== exp_jam || jam_data !== exp_data) begin
            n_fail++;
            $display("FAIL %s: jam_req=%0b jam_data=%b expected jam_req=%0b jam_data=%b",
                     req, jam_req, jam_data, exp_jam, exp_data);
        end
    endtask

    task automatic quiet();
        rx_sof = 0; rx_crs = 0; tx_busy = 0; rx_full = 0;
        rx_level = '0; rx_thresh = '1; half_duplex = 1;
        tick(); tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        tick(); tick();
        check("R1", 1'b0);
        rst_n = 1;
        tick();
        check("R1", 1'b0);

        // R2 / R8: sweep threshold, level, full flag
        for (int t = 0; t < 16; t++) begin
            for (int l = 0; l < 16; l++) begin
                for (int f = 0; f < 2; f++) begin
                    logic exp;
                    exp = (f == 1) || (l >= t);
                    rx_thresh = LW'(t); rx_level = LW'(l); rx_full = f[0];
                    tick();
                    rx_sof = 1;
                    tick();
                    rx_sof = 0;
                    check("R2", exp);
                    quiet();
                    check("R6", 1'b0);
                end
            end
        end

        // R4: transmission in progress when armed
        rx_thresh = 4'd8; rx_level = 4'd9; tx_busy = 1;
        tick();
        rx_sof = 1; tick(); rx_sof = 0;
        check("R4", 1'b0);
        tick();
        check("R4", 1'b0);
        tx_busy = 0; tick();
        check("R4", 1'b0);
        rx_sof = 1; tick(); rx_sof = 0;
        check("R4", 1'b1);
        quiet();

        // R5: sof in the arming cycle is not acted upon
        rx_thresh = 4'd8; rx_level = 4'd12; rx_sof = 1;
        tick(); rx_sof = 0;
        check("R5", 1'b0);
        tick();
        check("R5", 1'b0);
        rx_sof = 1; tick(); rx_sof = 0;
        check("R5", 1'b1);

        // R6: jam hold and exit
        rx_crs = 1; rx_level = 4'd2;
        tick(); check("R6", 1'b1);
        rx_crs = 0; rx_level = 4'd10;
        tick(); check("R6", 1'b1);
        rx_full = 1; rx_level = 4'd0;
        tick(); check("R6", 1'b1);
        rx_full = 0;
        tick(); check("R6", 1'b0);
        quiet();

        // R7: disarm before a frame starts
        rx_thresh = 4'd5; rx_level = 4'd7;
        tick(); check("R7", 1'b0);
        rx_level = 4'd3;
        tick(); check("R7", 1'b0);
        rx_sof = 1; tick(); rx_sof = 0;
        check("R7", 1'b0);
        tick(); check("R7", 1'b0);
        quiet();

        // R3: full duplex never jams
        half_duplex = 0; rx_thresh = 4'd4; rx_level = 4'd15; rx_full = 1;
        tick();
        rx_sof = 1; tick(); rx_sof = 0;
        check("R3", 1'b0);
        tick(); check("R3", 1'b0);
        // R3: dropping half duplex ends a jam
        half_duplex = 1; tick();
        rx_sof = 1; tick(); rx_sof = 0;
        check("R3", 1'b1);
        rx_crs = 1; half_duplex = 0;
        tick(); check("R3", 1'b0);
        quiet();

        // R9: frame already on the wire when armed
        rx_crs = 1; tick();
        rx_thresh = 4'd6; rx_level = 4'd6;
        for (int k = 0; k < 4; k++) begin
            tick(); check("R9", 1'b0);
        end
        rx_crs = 0; tick(); check("R9", 1'b0);
        rx_sof = 1; rx_crs = 1; tick(); rx_sof = 0;
        check("R9", 1'b1);
        check("R8", 1'b1);
        quiet();
        check("R8", 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule